// File: doc/BRIEF.md
# Registered PAL Macrocell Array

This block models a programmable array logic device. A programmable AND plane forms product terms from the device inputs and from the section outputs fed back into the array, each in true or complemented form. A fixed OR plane then sums a small dedicated group of product terms for each output section. No product term is shared between sections.

Each section is either combinational or registered through a D flip-flop, chosen by its own configuration bit. A section output fed back as a literal lets one section build on another, for example Z = W + AC'D' + A'B'C'D. Registered sections with feedback give state machines such as counters.

The configuration is loaded serially through a shift port. A combinational feedback cycle has no stable meaning, so it is detected and reported on an error output.

Top module: `pal_array`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears every output register and every configuration bit to 0. With an all-zero configuration, all outputs read 0 and `cfg_err` reads 0.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_in` into configuration bit 0 and moves every bit up one place, so the first bit shifted ends at the top bit `CFG_W-1`. Section k occupies bits `k*SEC_W` upward. Its bit 0 is the mode bit (1 = registered). Row j literal column c sits at offset `1 + j*N_LIT + c`. While `cfg_en` is low, the configuration holds.
- R3: Literal column c = 2*s + p refers to signal s, where s < N_IN is input `pin_in[s]` and s >= N_IN is the feedback of section s-N_IN. The value p = 1 means the complement. A configuration bit of 1 removes that literal from the product. A product term is the AND of its remaining literals, and a row with every literal removed evaluates to 1.
- R4: A row that keeps both polarities of any signal evaluates to 0 and does not affect its section. This includes an untouched row with all literals kept.
- R5: A combinational section's output is the OR of its own P_PER product terms, in the same cycle as the inputs.
- R6: A registered section's flip-flop loads the section's OR result at each rising edge where `cfg_en` is low. The section output and its feedback both carry the flip-flop value.
- R7: The feedback of a combinational section carries its OR result, so chains of combinational sections resolve within the same cycle.
- R8: `cfg_err` is high exactly when the combinational sections form a dependency cycle through rows that are not constant 0. It is low for acyclic chains, for cycles broken by a registered section, and for self-references in dead rows.
- R9: While `cfg_en` is high, the output flip-flops hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration bit |
| pin_in | input | N_IN | Device inputs |
| pin_out | output | N_OUT | Section outputs |
| cfg_err | output | 1 | Combinational feedback cycle detected |

## Verification
The bench builds the block with its defaults: 4 inputs, 4 sections and 3 product terms per section, which gives 16 literal columns and a 196-bit configuration. With these values the bench can walk all 16 input combinations through a four-function set in which one section reuses another as a literal. It can also run a 2-bit counter built from registered feedback, and form a two-section cycle, a self-loop and a dead-row self-reference to exercise the loop flag.

// File: rtl/pal_pkg.sv
package pal_pkg;
    // offset of the mode bit inside a section slice
    localparam int MODE_OFS = 0;
    // offset of the first row literal bit inside a section slice
    localparam int ROW_OFS  = 1;

    // literal column of signal sig, complemented when inv is set
    function automatic int lit_col(input int sig, input bit inv);
        return 2 * sig + (inv ? 1 : 0);
    endfunction
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int CFG_W = 196
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [CFG_W-1:0] cfg_o
);
    typedef struct packed {
        logic [CFG_W-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[CFG_W-2:0], shift_in};
        end
        if (!rst_n) begin
            st_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_o = st_q.bits;
endmodule

// File: rtl/pal_and_or.sv
module pal_and_or #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int P_PER = 3
) (
    input  logic [N_IN+N_OUT-1:0]           sig_i,
    input  logic [N_OUT*P_PER*2*(N_IN+N_OUT)-1:0] cut_i,
    output logic [N_OUT-1:0]                or_o
);
    import pal_pkg::*;

    localparam int N_SIG  = N_IN + N_OUT;
    localparam int N_LIT  = 2 * N_SIG;
    localparam int N_ROWS = N_OUT * P_PER;

    logic [N_LIT-1:0]  lit;
    logic [N_ROWS-1:0] prod;

    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lit[lit_col(s, 1'b0)] = sig_i[s];
        assign lit[lit_col(s, 1'b1)] = ~sig_i[s];
    end

    // a removed literal reads as 1, so it drops out of the AND
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        assign prod[r] = &(lit | cut_i[r*N_LIT +: N_LIT]);
    end

    // each section sums only its own dedicated rows
    for (genvar k = 0; k < N_OUT; k++) begin : g_sum
        assign or_o[k] = |prod[k*P_PER +: P_PER];
    end
endmodule

// File: rtl/pal_loop_check.sv
module pal_loop_check #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int P_PER = 3
) (
    input  logic [N_OUT*P_PER*2*(N_IN+N_OUT)-1:0] cut_i,
    input  logic [N_OUT-1:0]                      mode_i,
    output logic                                  err_o
);
    localparam int N_SIG = N_IN + N_OUT;
    localparam int N_LIT = 2 * N_SIG;

    logic [N_OUT-1:0][N_OUT-1:0] dep;
    logic [N_OUT-1:0][N_OUT-1:0] reach;
    logic [N_LIT-1:0]            row;
    logic                        live;

    always_comb begin
        dep   = '0;
        row   = '0;
        live  = 1'b0;
        // direct edges: combinational section j reads combinational section k
        for (int j = 0; j < N_OUT; j++) begin
            for (int r = 0; r < P_PER; r++) begin
                row  = cut_i[(j*P_PER + r)*N_LIT +: N_LIT];
                live = 1'b1;
                for (int s = 0; s < N_SIG; s++) begin
                    if (!row[2*s] && !row[2*s+1]) begin
                        live = 1'b0;
                    end
                end
                for (int k = 0; k < N_OUT; k++) begin
                    if (live && !mode_i[j] && !mode_i[k] &&
                        (!row[2*(N_IN+k)] || !row[2*(N_IN+k)+1])) begin
                        dep[j][k] = 1'b1;
                    end
                end
            end
        end
        // transitive closure
        reach = dep;
        for (int it = 0; it < N_OUT; it++) begin
            for (int j = 0; j < N_OUT; j++) begin
                for (int k = 0; k < N_OUT; k++) begin
                    if (reach[j][k]) begin
                        reach[j] = reach[j] | dep[k];
                    end
                end
            end
        end
        err_o = 1'b0;
        for (int j = 0; j < N_OUT; j++) begin
            err_o = err_o | reach[j][j];
        end
    end
endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int P_PER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_in,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic             cfg_err
);
    import pal_pkg::*;

    localparam int N_SIG    = N_IN + N_OUT;
    localparam int N_LIT    = 2 * N_SIG;
    localparam int ROW_BITS = P_PER * N_LIT;
    localparam int SEC_W    = ROW_OFS + ROW_BITS;
    localparam int CFG_W    = N_OUT * SEC_W;

    typedef struct packed {
        logic [N_OUT-1:0] q;
    } regs_t;

    regs_t st_d, st_q;

    logic [CFG_W-1:0]          cfg_bits;
    logic [N_OUT-1:0]          mode;
    logic [N_OUT*ROW_BITS-1:0] cut;
    logic [N_OUT-1:0]          or_res;

    pal_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .shift_in (cfg_in),
        .cfg_o    (cfg_bits)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_split
        assign mode[k] = cfg_bits[k*SEC_W + MODE_OFS];
        assign cut[k*ROW_BITS +: ROW_BITS] = cfg_bits[k*SEC_W + ROW_OFS +: ROW_BITS];
    end

    // unrolled evaluation passes settle acyclic combinational chains
    for (genvar g = 0; g < N_OUT; g++) begin : g_pass
        logic [N_OUT-1:0] fb_in;
        logic [N_OUT-1:0] or_v;
        logic [N_OUT-1:0] fb_out;

        if (g == 0) begin : g_first
            assign fb_in = mode & st_q.q;
        end else begin : g_next
            assign fb_in = g_pass[g-1].fb_out;
        end

        pal_and_or #(.N_IN(N_IN), .N_OUT(N_OUT), .P_PER(P_PER)) u_eval (
            .sig_i ({fb_in, pin_in}),
            .cut_i (cut),
            .or_o  (or_v)
        );

        assign fb_out = (mode & st_q.q) | (~mode & or_v);
    end

    assign or_res  = g_pass[N_OUT-1].or_v;
    assign pin_out = g_pass[N_OUT-1].fb_out;

    pal_loop_check #(.N_IN(N_IN), .N_OUT(N_OUT), .P_PER(P_PER)) u_loop (
        .cut_i  (cut),
        .mode_i (mode),
        .err_o  (cfg_err)
    );

    always_comb begin
        st_d = st_q;
        if (!cfg_en) begin
            st_d.q = or_res;
        end
        if (!rst_n) begin
            st_d.q = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
    parameter int N_OUT = 4,
    parameter int CFG_W = 196
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_in,
    input logic [CFG_W-1:0] cfg_bits,
    input logic [N_OUT-1:0] q,
    input logic [N_OUT-1:0] or_res,
    input logic [N_OUT-1:0] mode,
    input logic             cfg_err
);
    logic seen = 1'b0;

    always_ff @(posedge clk) begin
        seen <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!rst_n)) |-> (q == '0 && cfg_bits == '0)); // R1

    AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cfg_en) |=> (cfg_bits[0] == $past(cfg_in) &&
                              cfg_bits[CFG_W-1:1] == $past(cfg_bits[CFG_W-2:0]))); // R2

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !cfg_en) |=> $stable(cfg_bits)); // R2

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !cfg_en) |=> (q == $past(or_res))); // R6

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cfg_en) |=> $stable(q)); // R9

    AST_ALL_REG_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (&mode) |-> !cfg_err); // R8
endmodule

bind pal_array pal_array_chk #(.N_OUT(N_OUT), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_in   (cfg_in),
    .cfg_bits (cfg_bits),
    .q        (st_q.q),
    .or_res   (or_res),
    .mode     (mode),
    .cfg_err  (cfg_err)
);

// File: tb/pal_array_test.sv
module pal_array_test;
    localparam int PERIOD = 10;
    localparam int N_IN   = 4;
    localparam int N_OUT  = 4;
    localparam int P_PER  = 3;
    localparam int N_LIT  = 2 * (N_IN + N_OUT);
    localparam int SEC_W  = 1 + P_PER * N_LIT;
    localparam int CFG_W  = N_OUT * SEC_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_en;
    logic             cfg_in;
    logic [N_IN-1:0]  pin_in;
    logic [N_OUT-1:0] pin_out;
    logic             cfg_err;

    pal_array #(.N_IN(N_IN), .N_OUT(N_OUT), .P_PER(P_PER)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_in),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .cfg_err (cfg_err)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic [N_OUT-1:0] out;
        logic [N_OUT-1:0] mask;
        logic             err;
        string            tag;
    } item_t;

    item_t            sb[$];
    int               checks = 0;
    int               fails  = 0;
    bit               done   = 1'b0;
    logic [CFG_W-1:0] img;

    // configuration image helpers
    task automatic set_reg(input int k);
        img[k*SEC_W] = 1'b1;
    endtask

    task automatic open_row(input int k, input int r);
        for (int c = 0; c < N_LIT; c++) img[k*SEC_W + 1 + r*N_LIT + c] = 1'b1;
    endtask

    task automatic lit(input int k, input int r, input int s, input int inv);
        img[k*SEC_W + 1 + r*N_LIT + 2*s + inv] = 1'b0;
    endtask

    task automatic load_img();
        for (int i = CFG_W - 1; i >= 0; i--) begin
            @(negedge clk);
            rst_n  = 1'b1;
            cfg_en = 1'b1;
            cfg_in = img[i];
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        cfg_en = 1'b0;
        img    = '0;
    endtask

    // driver: apply one input vector and queue the expected result
    task automatic step(input logic [N_IN-1:0] v, input logic [N_OUT-1:0] eo,
                        input logic [N_OUT-1:0] m, input logic ee, input string tag);
        item_t it;
        @(negedge clk);
        rst_n  = 1'b1;
        cfg_en = 1'b0;
        pin_in = v;
        it.out = eo; it.mask = m; it.err = ee; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic reset_step(input logic [N_IN-1:0] v, input string tag);
        item_t it;
        @(negedge clk);
        rst_n  = 1'b0;
        cfg_en = 1'b0;
        pin_in = v;
        it.out = '0; it.mask = '1; it.err = 1'b0; it.tag = tag;
        sb.push_back(it);
    endtask

    // expected functions, inputs a=pin_in[0] .. d=pin_in[3]
    function automatic logic [3:0] exp_comb(input logic [3:0] v);
        logic a, b, c, d, w, x, y, z;
        a = v[0]; b = v[1]; c = v[2]; d = v[3];
        w = (a & b & ~c) | (~a & ~b & c & ~d);
        x = a | (b & c & d);
        y = (~a & b) | (c & d) | (~b & ~d);
        z = w | (a & ~c & ~d) | (~a & ~b & ~c & d);
        return {z, y, x, w};
    endfunction

    // monitor: sample a quarter period after the edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if ((((pin_out ^ it.out) & it.mask) != '0) || (cfg_err !== it.err)) begin
                    fails++;
                    $display("FAIL %s: actual out=%b err=%b expected out=%b err=%b (mask %b)",
                             it.tag, pin_out, cfg_err, it.out, it.err, it.mask);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..: actual=still running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] cnt;
        logic [3:0] v;
        rst_n  = 1'b0;
        cfg_en = 1'b0;
        cfg_in = 1'b0;
        pin_in = '0;
        img    = '0;
        repeat (3) @(negedge clk);
        reset_step(4'hF, "R1 reset state");

        // four functions, section 3 reuses section 0 as a literal
        img = '0;
        open_row(0, 0); lit(0, 0, 0, 0); lit(0, 0, 1, 0); lit(0, 0, 2, 1);
        open_row(0, 1); lit(0, 1, 0, 1); lit(0, 1, 1, 1); lit(0, 1, 2, 0); lit(0, 1, 3, 1);
        open_row(1, 0); lit(1, 0, 0, 0);
        open_row(1, 1); lit(1, 1, 1, 0); lit(1, 1, 2, 0); lit(1, 1, 3, 0);
        open_row(2, 0); lit(2, 0, 0, 1); lit(2, 0, 1, 0);
        open_row(2, 1); lit(2, 1, 2, 0); lit(2, 1, 3, 0);
        open_row(2, 2); lit(2, 2, 1, 1); lit(2, 2, 3, 1);
        open_row(3, 0); lit(3, 0, 4, 0);
        open_row(3, 1); lit(3, 1, 0, 0); lit(3, 1, 2, 1); lit(3, 1, 3, 1);
        open_row(3, 2); lit(3, 2, 0, 1); lit(3, 2, 1, 1); lit(3, 2, 2, 1); lit(3, 2, 3, 0);
        load_img();
        for (int i = 0; i < 16; i++) begin
            step(4'(i), exp_comb(4'(i)), 4'hF, 1'b0, "R2 R3 R5 R7 chained sum of products");
        end
        reset_step(4'hF, "R1 reset clears configured outputs");
        step(4'hF, 4'h0, 4'hF, 1'b0, "R1 configuration cleared by reset");

        // 2-bit counter in sections 0,1; dead rows in section 2; delay in 3
        pulse_reset();
        open_row(0, 0); lit(0, 0, 4, 1); set_reg(0);
        open_row(1, 0); lit(1, 0, 5, 0); lit(1, 0, 4, 1);
        open_row(1, 1); lit(1, 1, 5, 1); lit(1, 1, 4, 0); set_reg(1);
        open_row(2, 0); lit(2, 0, 0, 0); lit(2, 0, 1, 0);
        open_row(2, 1); lit(2, 1, 0, 0); lit(2, 1, 0, 1); lit(2, 1, 1, 0);
        open_row(3, 0); lit(3, 0, 0, 0); set_reg(3);
        load_img();
        cnt = 2'd0;
        for (int i = 0; i < 8; i++) begin
            v   = 4'((i * 5 + 3) & 15);
            cnt = cnt + 2'd1;
            step(v, {v[0], v[0] & v[1], cnt}, 4'hF, 1'b0, "R4 R6 R9 registered feedback counter");
        end

        // two combinational sections reading each other
        pulse_reset();
        open_row(0, 0); lit(0, 0, 5, 0);
        open_row(1, 0); lit(1, 0, 4, 0);
        load_img();
        step(4'h0, 4'h0, 4'h0, 1'b1, "R8 two-section loop flagged");
        step(4'hF, 4'h0, 4'h0, 1'b1, "R8 two-section loop flagged");

        // same loop broken by a register in section 1
        pulse_reset();
        open_row(0, 0); lit(0, 0, 5, 0);
        open_row(1, 0); lit(1, 0, 4, 0); set_reg(1);
        load_img();
        step(4'h3, 4'h0, 4'hF, 1'b0, "R8 loop through register not flagged");

        // self reference only in a dead row
        pulse_reset();
        open_row(0, 0); lit(0, 0, 4, 0); lit(0, 0, 4, 1); lit(0, 0, 0, 0);
        open_row(0, 1); lit(0, 1, 1, 0);
        load_img();
        step(4'b0010, 4'b0001, 4'hF, 1'b0, "R4 R8 dead self-referencing row");
        step(4'b0001, 4'b0000, 4'hF, 1'b0, "R4 R8 dead self-referencing row");

        // live self loop on section 2
        pulse_reset();
        open_row(2, 0); lit(2, 0, 6, 1);
        load_img();
        step(4'h0, 4'h0, 4'h0, 1'b1, "R8 self loop flagged");

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule